// File: doc/BRIEF.md
# Flash Erase Block Selector

This block holds the erase-target selection for an on-chip flash array of eleven blocks. The selection lives in two 8-bit bus-visible registers. The low register carries the selection bits for blocks 7 to 0. The high register carries the bits for blocks 10 to 8 in its three lowest positions. A block whose bit is 1 may be erased, and every block whose bit is 0 is protected. The combined 11-bit mask goes to the erase machinery.

Alongside the mask, the block drives a single permit qualifier. The flash control register uses this qualifier to accept or refuse writes to its erase-setup and erase bits. The qualifier is high only when exactly one of the eleven bits is set. With no bit set, or with two or more bits set in either register or spread across both, it stays low.

The selection is wiped by several protection conditions, and each of them beats a bus write made in the same cycle. While the flash is disabled, the registers read as zero and ignore writes, but they keep their contents. The bus side is a plain register port with no back-pressure: every write strobe is taken in the cycle it is presented, and no ready signal exists.

Top module: `flash_erase_sel`

## Requirements
- R1: After power-on reset (`por_n` low, asynchronous) both registers read 0x00, `erase_mask` is 0 and `erase_permit` is 0.
- R2: A write strobe with `reg_sel`=0 and flash enabled loads `wr_data` into mask bits 7..0 on the next rising clock edge. The read data shows the new value combinationally from then on.
- R3: A write with `reg_sel`=1 loads only `wr_data[2:0]` into mask bits 10..8. Register bits 7..3 always read 0, and writing them has no effect.
- R4: While `standby` is high, both registers are cleared at each clock edge, even if a write is presented in that cycle.
- R5: While `wp_pin` is high, both registers are cleared at each clock edge, even if a write is presented in that cycle.
- R6: While `wp_pin` is low and `sw_wr_en` is low, both registers are cleared at each clock edge, even if a write is presented in that cycle.
- R7: While `flash_en` is low, `rd_data` is 0x00 and writes leave the stored selection and `erase_mask` unchanged.
- R8: `erase_permit` is 1 exactly when one bit of the 11-bit mask is set, whichever register holds it.
- R9: `erase_permit` is 0 when no mask bit is set. It is also 0 when two or more bits are set, whether they sit in one register or in both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| standby | input | 1 | Standby mode, clears selection |
| wp_pin | input | 1 | Write-protect pin level, high clears selection |
| sw_wr_en | input | 1 | Software write enable bit from the control register |
| flash_en | input | 1 | On-chip flash enabled |
| reg_sel | input | 1 | Register select: 0 low (blocks 7..0), 1 high (blocks 10..8) |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| erase_mask | output | 11 | Erase-enabled blocks, bit n is block n |
| erase_permit | output | 1 | Exactly one block selected |

## Verification
A write or a clear shows on `erase_mask`, `erase_permit` and `rd_data` after the next rising edge. The driver applies stimulus on a falling edge and queues the expected mask and permit after the following rising edge. The monitor pops and compares the queued values on the next falling edge, so each comparison lands one edge after its cause. Reads are combinational: the bench sets `reg_sel` on a falling edge and samples `rd_data` 1 ns later, with no edge in between.

// File: rtl/fes_pkg.sv
package fes_pkg;
  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // number of implemented bits in register idx
  function automatic int impl_bits(input int blocks, input int reg_w, input int idx);
    int rest;
    rest = blocks - idx * reg_w;
    if (rest >= reg_w) return reg_w;
    if (rest < 0) return 0;
    return rest;
  endfunction

  function automatic int sel_width(input int nreg);
    return (nreg > 1) ? $clog2(nreg) : 1;
  endfunction
endpackage

// File: rtl/fes_guard.sv
module fes_guard (
  input  logic standby,
  input  logic wp_pin,
  input  logic sw_wr_en,
  output logic clr
);
  logic pin_block, sw_block;
  always_comb begin
    pin_block = wp_pin;
    sw_block  = !wp_pin && !sw_wr_en;
    clr       = standby || pin_block || sw_block;
  end
endmodule

// File: rtl/fes_bank_reg.sv
module fes_bank_reg #(
  parameter int REG_W  = 8,
  parameter int IMPL_W = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q
);
  localparam logic [REG_W-1:0] KEEP = REG_W'((64'd1 << IMPL_W) - 64'd1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (wr_en) q <= wr_data & KEEP;
  end

  // R4 R5 R6: clear wins over a same-cycle write
  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!por_n)
    clr |=> (q == '0));
  // R2: write lands one edge later
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !clr) |=> (q == ($past(wr_data) & KEEP)));
  // R7: no write, no clear -> contents kept
  p_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!wr_en && !clr) |=> $stable(q));
  // R3: unimplemented bits stay zero
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!por_n)
    ((q & ~KEEP) == '0));
endmodule

// File: rtl/fes_single_sel.sv
module fes_single_sel #(
  parameter int N = 11
) (
  input  logic [N-1:0] mask,
  output logic         permit
);
  logic [N:0] seen;
  logic [N:0] multi;
  assign seen[0]  = 1'b0;
  assign multi[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | mask[i];
    assign multi[i+1] = multi[i] | (seen[i] & mask[i]);
  end

  assign permit = seen[N] & ~multi[N];

  always_comb begin
    // R8: permit implies exactly one bit
    if (permit) p_permit_one_r8: assert ($countones(mask) == 1);
    // R9: zero or several bits -> no permit
    if ($countones(mask) != 1) p_no_permit_r9: assert (!permit);
  end
endmodule

// File: rtl/flash_erase_sel.sv
module flash_erase_sel #(
  parameter int BLOCKS = 11,
  parameter int REG_W  = 8
) (
  input  logic                                clk,
  input  logic                                por_n,
  input  logic                                standby,
  input  logic                                wp_pin,
  input  logic                                sw_wr_en,
  input  logic                                flash_en,
  input  logic [fes_pkg::sel_width(fes_pkg::ceil_div(BLOCKS, REG_W))-1:0] reg_sel,
  input  logic                                wr_stb,
  input  logic [REG_W-1:0]                    wr_data,
  output logic [REG_W-1:0]                    rd_data,
  output logic [BLOCKS-1:0]                   erase_mask,
  output logic                                erase_permit
);
  import fes_pkg::*;
  localparam int NREG   = ceil_div(BLOCKS, REG_W);
  localparam int SEL_W  = sel_width(NREG);
  localparam int LAST_W = impl_bits(BLOCKS, REG_W, NREG - 1);

  logic clr;
  logic [REG_W-1:0]      bank_q [NREG];
  logic [NREG*REG_W-1:0] flat;

  fes_guard u_guard (
    .standby (standby),
    .wp_pin  (wp_pin),
    .sw_wr_en(sw_wr_en),
    .clr     (clr)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    logic wr_en;
    assign wr_en = wr_stb && flash_en && (reg_sel == SEL_W'(g));
    fes_bank_reg #(
      .REG_W (REG_W),
      .IMPL_W(impl_bits(BLOCKS, REG_W, g))
    ) u_reg (
      .clk    (clk),
      .por_n  (por_n),
      .clr    (clr),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .q      (bank_q[g])
    );
    assign flat[g*REG_W +: REG_W] = bank_q[g];
  end

  assign erase_mask = flat[BLOCKS-1:0];

  always_comb begin
    rd_data = '0;
    if (flash_en && (int'(reg_sel) < NREG)) rd_data = bank_q[reg_sel];
  end

  fes_single_sel #(.N(BLOCKS)) u_sel (
    .mask  (erase_mask),
    .permit(erase_permit)
  );

  // R7: disabled flash reads zero
  p_disabled_read_r7: assert property (@(posedge clk) disable iff (!por_n)
    !flash_en |-> (rd_data == '0));
  // R7: disabled flash ignores writes
  p_disabled_keep_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!flash_en && !standby && !wp_pin && sw_wr_en) |=> $stable(erase_mask));
  // R4
  p_standby_clear_r4: assert property (@(posedge clk) disable iff (!por_n)
    standby |=> (erase_mask == '0));
  // R5
  p_pin_clear_r5: assert property (@(posedge clk) disable iff (!por_n)
    wp_pin |=> (erase_mask == '0));
  // R6
  p_sw_clear_r6: assert property (@(posedge clk) disable iff (!por_n)
    (!wp_pin && !sw_wr_en) |=> (erase_mask == '0));
  // R3: reserved read bits of the last register
  p_reserved_read_r3: assert property (@(posedge clk) disable iff (!por_n)
    (reg_sel == SEL_W'(NREG - 1)) |-> ((rd_data >> LAST_W) == '0));
endmodule

// File: tb/flash_erase_sel_bench.sv
`timescale 1ns/1ps
module flash_erase_sel_bench;
  logic clk = 0, por_n = 0;
  logic standby = 0, wp_pin = 0, sw_wr_en = 1, flash_en = 1;
  logic reg_sel = 0, wr_stb = 0;
  logic [7:0]  wr_data = 0, rd_data;
  logic [10:0] erase_mask;
  logic        erase_permit;

  int errors = 0, checks = 0;
  logic done = 0;

  typedef struct { int req; logic [10:0] mask; logic permit; } exp_t;
  exp_t sb[$];
  logic [7:0] m_lo = 0, m_hi = 0;

  always #2.5 clk = ~clk;

  flash_erase_sel u_flash_erase_sel (
    .clk, .por_n, .standby, .wp_pin, .sw_wr_en, .flash_en,
    .reg_sel, .wr_stb, .wr_data, .rd_data, .erase_mask, .erase_permit
  );

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, then queue expected state
  task automatic step(input int req, input logic s, input logic w, input logic [7:0] d);
    logic c;
    @(negedge clk);
    reg_sel = s; wr_stb = w; wr_data = d;
    @(posedge clk);
    c = standby || wp_pin || !sw_wr_en;
    if (c) begin m_lo = 0; m_hi = 0; end
    else if (w && flash_en) begin
      if (!s) m_lo = d; else m_hi = d & 8'h07;
    end
    #1 wr_stb = 0;
    sb.push_back('{req, {m_hi[2:0], m_lo}, $countones({m_hi[2:0], m_lo}) == 1});
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.req, "mask", 32'(erase_mask), 32'(e.mask));
      chk(e.req, "permit", 32'(erase_permit), 32'(e.permit));
    end
  end

  task automatic rd(input int req, input logic s, input logic [7:0] exp);
    @(negedge clk);
    reg_sel = s;
    #1 chk(req, "rd_data", 32'(rd_data), 32'(exp));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 por_n = 1;
    // R1
    rd(1, 0, 8'h00); rd(1, 1, 8'h00);
    chk(1, "reset mask", 32'(erase_mask), 0);
    chk(1, "reset permit", 32'(erase_permit), 0);
    // R2 + R8 single low bit
    step(2, 0, 1, 8'h04); rd(2, 0, 8'h04);
    // R3 reserved bits masked, R9 several bits across both
    step(3, 1, 1, 8'hFF); rd(3, 1, 8'h07);
    step(9, 0, 1, 8'h00);
    step(8, 1, 1, 8'h02); rd(8, 1, 8'h02);
    step(9, 1, 1, 8'h00);               // R9 zero bits
    step(9, 0, 1, 8'h81);               // R9 two bits in one register
    // R7 disabled: reads zero, writes ignored
    flash_en = 0;
    rd(7, 0, 8'h00); rd(7, 1, 8'h00);
    step(7, 0, 1, 8'h01);
    step(7, 1, 1, 8'h04);
    flash_en = 1;
    rd(7, 0, 8'h81); rd(7, 1, 8'h00);
    // R4 standby clears, beats write
    step(8, 0, 1, 8'h10);
    standby = 1; step(4, 0, 1, 8'h20); rd(4, 0, 8'h00);
    standby = 0;
    // R5 write-protect pin
    step(8, 1, 1, 8'h01);
    wp_pin = 1; step(5, 0, 1, 8'h08); step(5, 1, 1, 8'h04);
    wp_pin = 0; rd(5, 1, 8'h00);
    // R6 software enable low
    step(8, 0, 1, 8'h40);
    sw_wr_en = 0; step(6, 0, 1, 8'h02); rd(6, 0, 8'h00);
    sw_wr_en = 1;
    step(2, 0, 1, 8'h01); rd(2, 0, 8'h01);
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule